// File: doc/BRIEF.md
# Serial Test Port with In-System Programming Sequencer

This block is a four-wire serial test port (clock, mode select, data in, data out) with no separate test-reset pin. A sixteen-state test controller walks the standard scan sequence. A four-bit instruction register picks which data register sits between the serial input and output: a one-bit pass-through, a 32-bit identification word, or a programming shift register. The programming shift register carries a row address above a row of data. The controller state and the instruction register return to their idle values only through the power-on reset or through the controller's own reset state.

Four instructions control a small array of rows held in flip-flops, which stands in for nonvolatile storage. One instruction unlocks programming. After that, the erase, program and verify instructions take effect when the controller passes through Update-DR. Erase and program are timed operations. Each holds a busy flag for a set number of test-clock cycles, and the array is written when that time ends. Verify reads a row back into the data field of the shift register so that the next data scan returns it.

Controller states: Reset, Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR. Each state moves on the value of TMS at the rising clock edge:

| State | Next state with TMS=1 | Next state with TMS=0 |
|---|---|---|
| Reset | Reset | Idle |
| Idle | Select-DR | Idle |
| Select-DR | Select-IR | Capture-DR |
| Capture-DR | Exit1-DR | Shift-DR |
| Shift-DR | Exit1-DR | Shift-DR |
| Exit1-DR | Update-DR | Pause-DR |
| Pause-DR | Exit2-DR | Pause-DR |
| Exit2-DR | Update-DR | Shift-DR |
| Update-DR | Select-DR | Idle |
| Select-IR | Reset | Capture-IR |
| Capture-IR | Exit1-IR | Shift-IR |
| Shift-IR | Exit1-IR | Shift-IR |
| Exit1-IR | Update-IR | Pause-IR |
| Pause-IR | Exit2-IR | Pause-IR |
| Exit2-IR | Update-IR | Shift-IR |
| Update-IR | Select-DR | Idle |

The array sequencer has three states:

| State | Entered when | Leaves to Idle when |
|---|---|---|
| Idle | reset, or a timed operation ends | — |
| Erasing | an erase start arrives while Idle | its countdown ends |
| Programming | a program start arrives while Idle | its countdown ends |

Top module: `isp_tap`

## Requirements
- R1: The power-on reset (por_n low) puts the controller in Reset and clears tdo_oe and busy. Five rising clock edges in a row with tms high always bring the controller to Reset.
- R2: Capture-IR loads the instruction shift register with 4'b0101. Shift-IR shifts it least significant bit first, and Update-IR copies it into the instruction register. The Reset state selects the identification instruction (4'b0001).
- R3: With instruction 4'b0001 selected, Capture-DR loads the 32-bit ID_VALUE parameter, whose bit 0 is 1, and it shifts out least significant bit first.
- R4: Instruction 4'b1111 and every code with no meaning select a one-bit pass-through register. That register captures 0 in Capture-DR, so a scan of n bits returns 0 followed by the first n-1 input bits.
- R5: Erase (4'b1010), program (4'b1011) and verify (4'b1100) act only after the unlock code (4'b1001) has passed through Update-IR. Before that they behave as the pass-through register and change nothing. The unlock holds until the controller enters Reset.
- R6: The unlock code and the unlocked programming codes select a shift register of ROW_ADDR_W+ROW_DATA_W bits. The row data sits in the low ROW_DATA_W bits and the row address above them. It shifts least significant bit first, and Capture-DR leaves its contents unchanged.
- R7: Under program, Update-DR starts a write of the data field into the row given by the address field. busy stays high for exactly PROG_CYCLES clock cycles, and then the row holds the data.
- R8: Under erase, Update-DR starts a clear of every row to zero. busy stays high for exactly ERASE_CYCLES clock cycles.
- R9: Under verify, Update-DR copies the row named by the address field into the data field of the shift register, which the next data scan returns.
- R10: A program, erase or verify Update-DR that arrives while busy is high has no effect on the array or on the shift register.
- R11: tms and tdi are sampled on the rising edge of tck. tdo_o and tdo_oe change only on the falling edge, and tdo_oe is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo_o | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Drive enable for tdo_o; high only while shifting |
| busy | output | 1 | High while a timed erase or program runs |

## Verification
The assertions assume that tms and tdi are stable around each rising edge of tck, and that por_n is asserted at power-up before any meaningful clock activity. The bench meets both assumptions: it changes its inputs only just after a falling edge and holds reset through the first cycles. The assertions on operation length also assume that a new start is never accepted while busy is high. The bench honours this deliberately: it waits for busy to clear before it issues each command it expects to run, except in the test that checks a command is ignored while busy.

// File: rtl/isp_tap_pkg.sv
package isp_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAUSE_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAUSE_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_PASS,
        DR_IDENT,
        DR_PROG
    } dr_sel_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_UNLOCK,
        CMD_ERASE,
        CMD_WRITE,
        CMD_READ
    } isp_cmd_e;

    typedef enum logic [1:0] {
        ARR_IDLE,
        ARR_ERASING,
        ARR_WRITING
    } arr_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] CODE_PASS    = 4'b1111;
    localparam logic [IR_W-1:0] CODE_IDENT   = 4'b0001;
    localparam logic [IR_W-1:0] CODE_UNLOCK  = 4'b1001;
    localparam logic [IR_W-1:0] CODE_ERASE   = 4'b1010;
    localparam logic [IR_W-1:0] CODE_WRITE   = 4'b1011;
    localparam logic [IR_W-1:0] CODE_READ    = 4'b1100;
    localparam logic [IR_W-1:0] IR_CAPTURE   = 4'b0101;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import isp_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_e state_q;
    tap_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_d = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_d = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_SH_DR:    state_d = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_EX1_DR:   state_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_d = tms ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   state_d = tms ? ST_UPD_DR   : ST_SH_DR;
            ST_UPD_DR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_d = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_d = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_SH_IR:    state_d = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_EX1_IR:   state_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_d = tms ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   state_d = tms ? ST_UPD_IR   : ST_SH_IR;
            ST_UPD_IR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    // state decode outputs
    always_comb begin
        state    = state_q;
        in_reset = (state_q == ST_RESET);
        cap_dr   = (state_q == ST_CAP_DR);
        sh_dr    = (state_q == ST_SH_DR);
        upd_dr   = (state_q == ST_UPD_DR);
        cap_ir   = (state_q == ST_CAP_IR);
        sh_ir    = (state_q == ST_SH_IR);
        upd_ir   = (state_q == ST_UPD_IR);
    end

endmodule

// File: rtl/ir_decode.sv
module ir_decode
    import isp_tap_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    input  logic            unlocked,
    output dr_sel_e         dr_sel,
    output isp_cmd_e        cmd
);

    always_comb begin
        dr_sel = DR_PASS;
        cmd    = CMD_NONE;
        case (ir)
            CODE_IDENT: begin
                dr_sel = DR_IDENT;
            end
            CODE_UNLOCK: begin
                dr_sel = DR_PROG;
                cmd    = CMD_UNLOCK;
            end
            CODE_ERASE: begin
                if (unlocked) begin
                    dr_sel = DR_PROG;
                    cmd    = CMD_ERASE;
                end
            end
            CODE_WRITE: begin
                if (unlocked) begin
                    dr_sel = DR_PROG;
                    cmd    = CMD_WRITE;
                end
            end
            CODE_READ: begin
                if (unlocked) begin
                    dr_sel = DR_PROG;
                    cmd    = CMD_READ;
                end
            end
            default: begin
                dr_sel = DR_PASS;
                cmd    = CMD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/isp_row_array.sv
module isp_row_array
    import isp_tap_pkg::*;
#(
    parameter int ADDR_W       = 2,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_erase,
    input  logic              start_prog,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int NUM_ROWS = 1 << ADDR_W;
    localparam int MAX_CYC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    arr_state_e              op_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [ADDR_W-1:0]       wr_addr_q;
    logic [DATA_W-1:0]       wr_data_q;
    logic                    finish;
    logic [NUM_ROWS-1:0][DATA_W-1:0] rows;

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= ARR_IDLE;
            cnt_q     <= '0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            unique case (op_q)
                ARR_IDLE: begin
                    if (start_erase) begin
                        op_q  <= ARR_ERASING;
                        cnt_q <= CNT_W'(ERASE_CYCLES - 1);
                    end else if (start_prog) begin
                        op_q      <= ARR_WRITING;
                        cnt_q     <= CNT_W'(PROG_CYCLES - 1);
                        wr_addr_q <= prog_addr;
                        wr_data_q <= prog_data;
                    end
                end
                ARR_ERASING, ARR_WRITING: begin
                    if (cnt_q == '0) begin
                        op_q <= ARR_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: op_q <= ARR_IDLE;
            endcase
        end
    end

    // sequencer outputs
    always_comb begin
        busy   = (op_q != ARR_IDLE);
        finish = busy && (cnt_q == '0);
    end

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        logic [DATA_W-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (finish && op_q == ARR_ERASING) begin
                row_q <= '0;
            end else if (finish && op_q == ARR_WRITING && wr_addr_q == ADDR_W'(g)) begin
                row_q <= wr_data_q;
            end
        end
        assign rows[g] = row_q;
    end

    assign rd_data = rows[rd_addr];

endmodule

// File: rtl/isp_tap.sv
module isp_tap
    import isp_tap_pkg::*;
#(
    parameter int          ROW_ADDR_W   = 2,
    parameter int          ROW_DATA_W   = 8,
    parameter int          PROG_CYCLES  = 4,
    parameter int          ERASE_CYCLES = 40,
    parameter logic [31:0] ID_VALUE     = 32'h0A35_C0DB
) (
    input  logic tck,
    input  logic por_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo_o,
    output logic tdo_oe,
    output logic busy
);

    localparam int SR_W = ROW_ADDR_W + ROW_DATA_W;
    localparam int ID_W = 32;

    tap_state_e state;
    logic in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;

    logic [IR_W-1:0]       ir_shift;
    logic [IR_W-1:0]       ir_q;
    logic                  unlocked;
    dr_sel_e               dr_sel;
    isp_cmd_e              cmd;
    logic                  pass_q;
    logic [ID_W-1:0]       id_sr;
    logic [SR_W-1:0]       isp_sr;
    logic [ROW_ADDR_W-1:0] sr_addr;
    logic [ROW_DATA_W-1:0] sr_data;
    logic [ROW_DATA_W-1:0] rd_data;
    logic                  start_prog;
    logic                  start_erase;
    logic                  load_read;
    logic                  dr_bit;

    tap_fsm u_fsm (
        .clk      (tck),
        .rst_n    (por_n),
        .tms      (tms),
        .state    (state),
        .in_reset (in_reset),
        .cap_dr   (cap_dr),
        .sh_dr    (sh_dr),
        .upd_dr   (upd_dr),
        .cap_ir   (cap_ir),
        .sh_ir    (sh_ir),
        .upd_ir   (upd_ir)
    );

    ir_decode u_dec (
        .ir       (ir_q),
        .unlocked (unlocked),
        .dr_sel   (dr_sel),
        .cmd      (cmd)
    );

    // instruction path
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_shift <= IR_CAPTURE;
            ir_q     <= CODE_IDENT;
            unlocked <= 1'b0;
        end else begin
            if (cap_ir) begin
                ir_shift <= IR_CAPTURE;
            end else if (sh_ir) begin
                ir_shift <= {tdi, ir_shift[IR_W-1:1]};
            end
            if (in_reset) begin
                ir_q     <= CODE_IDENT;
                unlocked <= 1'b0;
            end else if (upd_ir) begin
                ir_q <= ir_shift;
                if (ir_shift == CODE_UNLOCK) begin
                    unlocked <= 1'b1;
                end
            end
        end
    end

    assign sr_addr     = isp_sr[SR_W-1:ROW_DATA_W];
    assign sr_data     = isp_sr[ROW_DATA_W-1:0];
    assign start_prog  = upd_dr && (cmd == CMD_WRITE) && !busy;
    assign start_erase = upd_dr && (cmd == CMD_ERASE) && !busy;
    assign load_read   = upd_dr && (cmd == CMD_READ)  && !busy;

    // data registers
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            pass_q <= 1'b0;
            id_sr  <= '0;
            isp_sr <= '0;
        end else begin
            unique case (dr_sel)
                DR_PASS: begin
                    if (cap_dr) begin
                        pass_q <= 1'b0;
                    end else if (sh_dr) begin
                        pass_q <= tdi;
                    end
                end
                DR_IDENT: begin
                    if (cap_dr) begin
                        id_sr <= ID_VALUE;
                    end else if (sh_dr) begin
                        id_sr <= {tdi, id_sr[ID_W-1:1]};
                    end
                end
                DR_PROG: begin
                    if (sh_dr) begin
                        isp_sr <= {tdi, isp_sr[SR_W-1:1]};
                    end else if (load_read) begin
                        isp_sr[ROW_DATA_W-1:0] <= rd_data;
                    end
                end
                default: pass_q <= pass_q;
            endcase
        end
    end

    isp_row_array #(
        .ADDR_W       (ROW_ADDR_W),
        .DATA_W       (ROW_DATA_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_arr (
        .clk         (tck),
        .rst_n       (por_n),
        .start_erase (start_erase),
        .start_prog  (start_prog),
        .prog_addr   (sr_addr),
        .prog_data   (sr_data),
        .rd_addr     (sr_addr),
        .rd_data     (rd_data),
        .busy        (busy)
    );

    always_comb begin
        unique case (dr_sel)
            DR_IDENT: dr_bit = id_sr[0];
            DR_PROG:  dr_bit = isp_sr[0];
            default:  dr_bit = pass_q;
        endcase
    end

    // serial output on the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo_o  <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_o  <= sh_ir ? ir_shift[0] : dr_bit;
            tdo_oe <= sh_ir || sh_dr;
        end
    end

endmodule

// File: rtl/isp_tap_checker.sv
module isp_tap_checker
    import isp_tap_pkg::*;
#(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 40
) (
    input logic       tck,
    input logic       por_n,
    input logic       tms,
    input tap_state_e state,
    input logic [3:0] ir_shift,
    input logic       pass_q,
    input logic [31:0] id_sr,
    input dr_sel_e    dr_sel,
    input logic       busy,
    input logic       start_prog,
    input logic       start_erase,
    input logic       unlocked,
    input logic       tdo_oe
);

    logic [2:0]  tms_run;
    logic [15:0] busy_run;
    logic        last_was_erase;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            tms_run        <= '0;
            busy_run       <= '0;
            last_was_erase <= 1'b0;
        end else begin
            if (!tms) begin
                tms_run <= '0;
            end else if (tms_run != 3'd5) begin
                tms_run <= tms_run + 1'b1;
            end
            busy_run <= busy ? busy_run + 1'b1 : '0;
            if (start_erase) begin
                last_was_erase <= 1'b1;
            end else if (start_prog) begin
                last_was_erase <= 1'b0;
            end
        end
    end

    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!por_n)
        (tms_run == 3'd5) |-> (state == ST_RESET));

    assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_shift == 4'b0101));

    assert_ident_lsb_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && dr_sel == DR_IDENT) |=> id_sr[0]);

    assert_pass_capture_R4: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && dr_sel == DR_PASS) |=> !pass_q);

    assert_start_gated_R5: assert property (@(posedge tck) disable iff (!por_n)
        (start_prog || start_erase) |-> (unlocked && !busy));

    assert_op_length_R8: assert property (@(posedge tck) disable iff (!por_n)
        $fell(busy) |-> (busy_run == (last_was_erase ? 16'(ERASE_CYCLES) : 16'(PROG_CYCLES))));

    assert_tdo_enable_R11: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind isp_tap isp_tap_checker #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .tck         (tck),
    .por_n       (por_n),
    .tms         (tms),
    .state       (state),
    .ir_shift    (ir_shift),
    .pass_q      (pass_q),
    .id_sr       (id_sr),
    .dr_sel      (dr_sel),
    .busy        (busy),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .unlocked    (unlocked),
    .tdo_oe      (tdo_oe)
);

// File: tb/sim_isp_tap.sv
`timescale 1ns/1ps
module sim_isp_tap;

    localparam int          AW     = 2;
    localparam int          DW     = 8;
    localparam int          SRW    = AW + DW;
    localparam int          NROWS  = 1 << AW;
    localparam int          PCYC   = 4;
    localparam int          ECYC   = 40;
    localparam logic [31:0] IDV    = 32'h0A35_C0DB;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo_o, tdo_oe, busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic s_tdo, s_oe, s_busy;
    int   oe_bad = 0;

    always #10 tck = ~tck;

    isp_tap #(
        .ROW_ADDR_W   (AW),
        .ROW_DATA_W   (DW),
        .PROG_CYCLES  (PCYC),
        .ERASE_CYCLES (ECYC),
        .ID_VALUE     (IDV)
    ) u0 (
        .tck    (tck),
        .por_n  (por_n),
        .tms    (tms),
        .tdi    (tdi),
        .tdo_o  (tdo_o),
        .tdo_oe (tdo_oe),
        .busy   (busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: sample outputs after the falling edge, then drive inputs
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #2;
        s_tdo  = tdo_o;
        s_oe   = tdo_oe;
        s_busy = busy;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] dout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i]);
            dout[i] = s_tdo;
            if (s_oe !== 1'b1) oe_bad++;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = s_tdo;
            if (s_oe !== 1'b1) oe_bad++;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        @(negedge tck); #2;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge tck); #2;
        end
    endtask

    function automatic logic [DW-1:0] row_pattern(input int r);
        return DW'((r * 8'h53 + 8'h1D) & 8'hFF);
    endfunction

    task automatic read_row(input int r, output logic [DW-1:0] val, output logic [AW-1:0] adr);
        logic [31:0] o;
        scan_dr(32'({AW'(r), DW'(0)}), SRW, o);
        scan_dr(32'({AW'(r), DW'(0)}), SRW, o);
        val = o[DW-1:0];
        adr = o[SRW-1:DW];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [3:0]  iro;
        logic [31:0] dro;
        logic [31:0] pat;
        logic [DW-1:0] v;
        logic [AW-1:0] a;
        int n;

        repeat (3) @(posedge tck);
        @(negedge tck);
        por_n = 1'b1;
        #2;
        check(tdo_oe === 1'b0, "R1 oe after reset", 32'(tdo_oe), 0);
        check(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);

        step(0, 0);
        step(0, 0);
        check(s_oe === 1'b0, "R11 oe low in idle", 32'(s_oe), 0);

        // identification selected out of reset
        scan_dr(32'hFFFF_FFFF, 32, dro);
        check(dro === IDV, "R3 ident after reset", dro, IDV);

        // sweep all instruction codes before unlock
        for (int c = 0; c < 16; c++) begin
            if (c == 9) continue;
            pat = 32'hA5C3_0F69 ^ (32'(c) * 32'h0101_1011);
            scan_ir(4'(c), iro);
            check(iro === 4'b0101, "R2 ir capture", 32'(iro), 32'h5);
            scan_dr(pat, 32, dro);
            if (c == 1) begin
                check(dro === IDV, "R3 ident code", dro, IDV);
            end else begin
                check(dro === {pat[30:0], 1'b0}, "R4 R5 pass-through", dro, {pat[30:0], 1'b0});
            end
            check(s_busy === 1'b0, "R5 locked command idle", 32'(s_busy), 0);
        end

        // unlock; programming register captures nothing
        scan_ir(4'b1001, iro);
        scan_dr(32'h0, SRW, dro);
        check(dro === 32'h0, "R6 capture holds", dro, 0);

        // rows untouched by locked commands
        scan_ir(4'b1100, iro);
        for (int r = 0; r < NROWS; r++) begin
            read_row(r, v, a);
            check(v === '0, "R5 row unchanged", 32'(v), 0);
            check(a === AW'(r), "R6 address field", 32'(a), 32'(r));
        end

        // program every row
        scan_ir(4'b1011, iro);
        for (int r = 0; r < NROWS; r++) begin
            scan_dr(32'({AW'(r), row_pattern(r)}), SRW, dro);
            count_busy(n);
            check(n == PCYC, "R7 program busy length", 32'(n), 32'(PCYC));
        end

        scan_ir(4'b1100, iro);
        for (int r = 0; r < NROWS; r++) begin
            read_row(r, v, a);
            check(v === row_pattern(r), "R7 R9 row readback", 32'(v), 32'(row_pattern(r)));
        end

        // erase
        scan_ir(4'b1010, iro);
        scan_dr(32'h0, SRW, dro);
        count_busy(n);
        check(n == ECYC, "R8 erase busy length", 32'(n), 32'(ECYC));
        scan_ir(4'b1100, iro);
        for (int r = 0; r < NROWS; r++) begin
            read_row(r, v, a);
            check(v === '0, "R8 row cleared", 32'(v), 0);
        end

        // program row 1, then erase and try to program during busy
        scan_ir(4'b1011, iro);
        scan_dr(32'({AW'(1), 8'h5A}), SRW, dro);
        count_busy(n);
        scan_ir(4'b1010, iro);
        scan_dr(32'h0, SRW, dro);
        scan_ir(4'b1011, iro);
        scan_dr(32'({AW'(2), 8'hC3}), SRW, dro);
        check(s_busy === 1'b1, "R10 busy during program attempt", 32'(s_busy), 1);
        count_busy(n);
        scan_ir(4'b1100, iro);
        read_row(1, v, a);
        check(v === '0, "R10 row1 erased", 32'(v), 0);
        read_row(2, v, a);
        check(v === '0, "R10 row2 not programmed", 32'(v), 0);

        // read during busy leaves register alone
        scan_ir(4'b1011, iro);
        scan_dr(32'({AW'(3), 8'h96}), SRW, dro);
        count_busy(n);
        scan_ir(4'b1010, iro);
        scan_dr(32'({AW'(3), 8'h3C}), SRW, dro);
        scan_ir(4'b1100, iro);
        scan_dr(32'({AW'(3), 8'h3C}), SRW, dro);
        scan_dr(32'h0, SRW, dro);
        check(dro[DW-1:0] === 8'h3C, "R10 read ignored while busy", 32'(dro[DW-1:0]), 32'h3C);
        count_busy(n);

        // five TMS ones reset the port and the unlock
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        scan_dr(32'h0, 32, dro);
        check(dro === IDV, "R1 R2 ident after tms reset", dro, IDV);
        scan_ir(4'b1010, iro);
        pat = 32'h0000_00B6;
        scan_dr(pat, 8, dro);
        check(dro[7:0] === {pat[6:0], 1'b0}, "R5 unlock cleared", 32'(dro[7:0]), 32'({pat[6:0], 1'b0}));
        check(s_busy === 1'b0, "R5 no erase after reset", 32'(s_busy), 0);

        check(oe_bad == 0, "R11 oe during shift", 32'(oe_bad), 0);

        finish_run();
    end

endmodule